// File: doc/BRIEF.md
# Mean-Square Offset Calibration Unit

This unit removes the residual noise floor from the current-channel measurement path. It sits in front of the square-root stage and takes a stream of mean-square results, each marked by a valid strobe. The noise correction is held as a mean-square quantity, not as a linear amplitude. Every corrected result is the incoming mean square minus the stored offset, clipped so that it never drops below zero.

A calibrate command runs a short sequence. It first clears the stored offset. It then lets a programmable number of clock cycles pass so that the analog path can settle. After that it sums a power-of-two window of mean-square samples and keeps their average, found with a right shift, as the new offset. A one-cycle done pulse marks the update. Software can also load the offset directly through a small write port. After a gain change, software can rescale the offset by writing the new gain as a fixed-point multiplier, which avoids running the calibration again.

Top module: `msq_acoff`

## Requirements
- R1: After reset the stored offset is zero, `out_valid` and `cal_done` are low, and an incoming sample passes through unchanged.
- R2: Each sample with `smp_valid` high produces `out_valid` high on the next clock edge, with `out_msq` = `smp_msq` − offset when `smp_msq` ≥ offset.
- R3: When `smp_msq` < offset, `out_msq` is 0; the corrected result never wraps below zero.
- R4: `cal_start` taken while idle clears the offset to zero at that edge and begins settling; `cal_start` while a calibration is running is ignored.
- R5: With settle count S, samples presented at the first max(S,1) clock edges after the edge that captured `cal_start` are left out of the window.
- R6: The next 2^WIN_LOG2 valid samples are summed and the offset becomes floor(sum / 2^WIN_LOG2).
- R7: `cal_done` is high for exactly one cycle, at the edge that captures the last window sample; the offset takes its new value at that same edge.
- R8: With `wr_en` high and `wr_sel` = 0 while idle, the offset is loaded from `wr_data`.
- R9: With `wr_en` high and `wr_sel` = 1 while idle, the offset becomes min(floor(offset × g / 2^GAIN_FRAC), 2^DW − 1), where g = `wr_data[GAIN_W-1:0]` is unsigned (defaults: 16 bits, 14 fractional, so 0x4000 = 1.0).
- R10: Writes are ignored while a calibration runs, and the offset stays zero until the done edge. When `cal_start` and `wr_en` are both high in the same idle cycle, the start wins and the write is dropped.
- R11: `out_valid` is low on the cycle after any cycle in which `smp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Mean-square sample strobe |
| smp_msq | input | DW | Mean-square sample |
| cal_start | input | 1 | Start a calibration |
| settle_cycles | input | CW | Settling interval in clock cycles |
| wr_en | input | 1 | Offset register write strobe |
| wr_sel | input | 1 | 0: direct load, 1: gain rescale |
| wr_data | input | DW | Load value or gain (low GAIN_W bits) |
| out_valid | output | 1 | Corrected result strobe |
| out_msq | output | DW | Offset-corrected mean square |
| cal_done | output | 1 | One-cycle pulse when calibration updates the offset |

## Verification
The assertions watch the following properties on every cycle:
- each output strobe follows its input strobe one cycle later;
- the corrected value never rises above the sample that produced it;
- the done pulse lasts exactly one cycle and only ends an accumulation phase;
- a start command clears the offset;
- the offset does not move while settling.

Only the bench scenarios can show the exact arithmetic results: the subtraction, the window average and which samples fall inside the window for a given settle count. The same holds for the rounding and saturation of the gain rescale, and for the way a busy calibration throws away writes and repeated starts.

// File: rtl/msq_acoff_pkg.sv
package msq_acoff_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_ACCUM  = 2'd2
   } cal_st_e;
endpackage

// File: rtl/msq_settle_ctrl.sv
module msq_settle_ctrl
   import msq_acoff_pkg::*;
#(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_go,
   input  logic [CW-1:0] settle_cycles,
   input  logic          win_last,
   output cal_st_e       state
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_go) begin
                  state <= ST_SETTLE;
                  cnt_q <= settle_cycles;
               end
            end
            ST_SETTLE: begin
               if (cnt_q <= CW'(1)) state <= ST_ACCUM;
               else                 cnt_q <= cnt_q - CW'(1);
            end
            ST_ACCUM: begin
               if (win_last) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/msq_win_accum.sv
module msq_win_accum #(
   parameter int DW       = 24,
   parameter int WIN_LOG2 = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          take,
   input  logic [DW-1:0] smp,
   output logic          last,
   output logic [DW-1:0] mean
);
   localparam int AW = DW + WIN_LOG2;

   logic [AW-1:0]       acc_q;
   logic [AW-1:0]       sum;
   logic [WIN_LOG2-1:0] cnt_q;

   assign sum  = acc_q + AW'(smp);
   assign last = take & (&cnt_q);
   assign mean = DW'(sum >> WIN_LOG2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (take) begin
         acc_q <= last ? '0 : sum;
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/msq_offset_reg.sv
module msq_offset_reg #(
   parameter int DW        = 24,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 14,
   parameter bit SAT_SCALE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          load_mean,
   input  logic [DW-1:0] mean,
   input  logic          wr_dir,
   input  logic          wr_scale,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] offset_q
);
   localparam int PW = DW + GAIN_W;

   logic [GAIN_W-1:0] gain;
   logic [DW-1:0]     scaled;

   assign gain = wr_data[GAIN_W-1:0];

   generate
      if (SAT_SCALE) begin : g_sat
         logic [PW-1:0] shifted;
         assign shifted = (PW'(offset_q) * PW'(gain)) >> GAIN_FRAC;
         assign scaled  = (|shifted[PW-1:DW]) ? {DW{1'b1}} : shifted[DW-1:0];
      end else begin : g_wrap
         assign scaled = DW'((PW'(offset_q) * PW'(gain)) >> GAIN_FRAC);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         offset_q <= '0;
      else if (clear)     offset_q <= '0;
      else if (load_mean) offset_q <= mean;
      else if (wr_dir)    offset_q <= wr_data;
      else if (wr_scale)  offset_q <= scaled;
   end
endmodule

// File: rtl/msq_sub_stage.sv
module msq_sub_stage #(
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_msq,
   input  logic [DW-1:0] offset,
   output logic          out_valid,
   output logic [DW-1:0] out_msq
);
   logic [DW:0] diff;

   assign diff = {1'b0, in_msq} - {1'b0, offset};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_msq   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_msq <= diff[DW] ? '0 : diff[DW-1:0];
      end
   end
endmodule

// File: rtl/msq_acoff.sv
module msq_acoff
   import msq_acoff_pkg::*;
#(
   parameter int DW        = 24,
   parameter int CW        = 32,
   parameter int WIN_LOG2  = 4,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 14,
   parameter bit SAT_SCALE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic [DW-1:0] smp_msq,
   input  logic          cal_start,
   input  logic [CW-1:0] settle_cycles,
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [DW-1:0] wr_data,
   output logic          out_valid,
   output logic [DW-1:0] out_msq,
   output logic          cal_done
);
   generate
      if (WIN_LOG2 < 1 || WIN_LOG2 > 16) begin : g_bad_win
         $error("msq_acoff: WIN_LOG2 must lie in 1..16");
      end
      if (GAIN_W > DW) begin : g_bad_gw
         $error("msq_acoff: GAIN_W must not exceed DW");
      end
      if (GAIN_FRAC >= GAIN_W) begin : g_bad_frac
         $error("msq_acoff: GAIN_FRAC must be below GAIN_W");
      end
   endgenerate

   cal_st_e       state;
   logic          idle, start_go, wr_go, take, win_last;
   logic [DW-1:0] mean, offset_q;
   logic          done_q;

   assign idle     = (state == ST_IDLE);
   assign start_go = idle & cal_start;
   assign wr_go    = idle & wr_en & ~cal_start;
   assign take     = (state == ST_ACCUM) & smp_valid;

   msq_settle_ctrl #(.CW(CW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_go     (start_go),
      .settle_cycles(settle_cycles),
      .win_last     (win_last),
      .state        (state)
   );

   msq_win_accum #(.DW(DW), .WIN_LOG2(WIN_LOG2)) u_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(start_go),
      .take (take),
      .smp  (smp_msq),
      .last (win_last),
      .mean (mean)
   );

   msq_offset_reg #(
      .DW(DW), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .SAT_SCALE(SAT_SCALE)
   ) u_off (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start_go),
      .load_mean(win_last),
      .mean     (mean),
      .wr_dir   (wr_go & ~wr_sel),
      .wr_scale (wr_go & wr_sel),
      .wr_data  (wr_data),
      .offset_q (offset_q)
   );

   msq_sub_stage #(.DW(DW)) u_sub (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (smp_valid),
      .in_msq   (smp_msq),
      .offset   (offset_q),
      .out_valid(out_valid),
      .out_msq  (out_msq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= win_last;
   end
   assign cal_done = done_q;
endmodule

// File: rtl/msq_acoff_chk.sv
module msq_acoff_chk
   import msq_acoff_pkg::*;
#(
   parameter int DW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_valid,
   input logic [DW-1:0] smp_msq,
   input logic          cal_start,
   input logic          out_valid,
   input logic [DW-1:0] out_msq,
   input logic          cal_done,
   input cal_st_e       state,
   input logic [DW-1:0] offset_q
);
   AST_OUT_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> out_valid); // R2
   AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> !out_valid); // R11
   AST_OUT_NOT_ABOVE_IN: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> (out_msq <= $past(smp_msq))); // R3
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> !cal_done); // R7
   AST_DONE_FROM_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |-> ($past(state) == ST_ACCUM && state == ST_IDLE)); // R7
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && cal_start) |=> (offset_q == '0 && state == ST_SETTLE)); // R4
   AST_SETTLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SETTLE) |=> $stable(offset_q)); // R10
endmodule

bind msq_acoff msq_acoff_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp_valid(smp_valid),
   .smp_msq  (smp_msq),
   .cal_start(cal_start),
   .out_valid(out_valid),
   .out_msq  (out_msq),
   .cal_done (cal_done),
   .state    (state),
   .offset_q (offset_q)
);

// File: tb/msq_acoff_tb.sv
`timescale 1ns/1ps
module msq_acoff_tb;
   localparam int DW = 24;
   localparam int CW = 32;
   localparam int WL = 4;
   localparam int WN = 1 << WL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [DW-1:0] smp_msq = '0;
   logic          cal_start = 1'b0;
   logic [CW-1:0] settle_cycles = '0;
   logic          wr_en = 1'b0;
   logic          wr_sel = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          out_valid;
   logic [DW-1:0] out_msq;
   logic          cal_done;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 1'b0;

   always #2.5 clk = ~clk;

   msq_acoff #(.DW(DW), .CW(CW), .WIN_LOG2(WL)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_msq(smp_msq),
      .cal_start(cal_start), .settle_cycles(settle_cycles), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .out_valid(out_valid),
      .out_msq(out_msq), .cal_done(cal_done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic send_sample(input logic [DW-1:0] v, input logic [DW-1:0] exp, input string tag);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_msq   = v;
      @(negedge clk);
      smp_valid = 1'b0;
      chk({tag, " out_valid"}, 32'(out_valid), 32'd1);
      chk({tag, " out_msq"}, 32'(out_msq), 32'(exp));
   endtask

   task automatic write_reg(input logic sel, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [DW-1:0] cal_val(input int k, input int l, input int base);
      return (k <= l) ? 24'h900000 : DW'(base + k * 53);
   endfunction

   task automatic t_reset();
      chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
      chk("R1 cal_done after reset", 32'(cal_done), 32'd0);
      send_sample(24'h00ABCD, 24'h00ABCD, "R1 passthrough with zero offset");
   endtask

   task automatic t_subtract();
      write_reg(1'b0, 24'd1000);
      send_sample(24'd5000, 24'd4000, "R8 R2 direct offset subtract");
      send_sample(24'd1000, 24'd0, "R2 equal to offset");
      send_sample(24'd400, 24'd0, "R3 below offset clamps");
      @(negedge clk);
      chk("R11 no output without valid", 32'(out_valid), 32'd0);
   endtask

   task automatic t_rescale();
      write_reg(1'b0, 24'd1000);
      write_reg(1'b1, 24'h006000);
      send_sample(24'd5000, 24'd3500, "R9 gain 1.5");
      write_reg(1'b1, 24'h001000);
      send_sample(24'd5000, 24'd4625, "R9 gain 0.25");
      write_reg(1'b0, 24'h700000);
      write_reg(1'b1, 24'h008000);
      send_sample(24'hFFFFFF, 24'h1FFFFF, "R9 gain 2.0");
      write_reg(1'b1, 24'h008000);
      send_sample(24'hFFFFFF, 24'd0, "R9 saturates at full scale");
   endtask

   task automatic t_calibrate(input int s, input int base, input bit wr_with_start, input bit busy_poke);
      int l;
      int sum;
      logic [DW-1:0] exp_off;
      l = (s < 1) ? 1 : s;
      sum = 0;
      for (int k = l + 1; k <= l + WN; k++) sum += int'(cal_val(k, l, base));
      exp_off = DW'(sum >>> WL);
      write_reg(1'b0, 24'd777);
      @(negedge clk);
      cal_start = 1'b1;
      settle_cycles = CW'(s);
      if (wr_with_start) begin
         wr_en = 1'b1; wr_sel = 1'b0; wr_data = 24'd5;
      end
      for (int k = 1; k <= l + WN; k++) begin
         @(negedge clk);
         cal_start = 1'b0;
         wr_en = 1'b0;
         if (k > 1) begin
            chk("R4 R10 offset zero during calibration", 32'(out_msq), 32'(cal_val(k - 1, l, base)));
            chk("R7 no early done", 32'(cal_done), 32'd0);
         end
         if (busy_poke && k == 2) cal_start = 1'b1;
         if (busy_poke && k == 3) begin
            wr_en = 1'b1; wr_sel = 1'b0; wr_data = 24'h000777;
         end
         smp_valid = 1'b1;
         smp_msq = cal_val(k, l, base);
      end
      @(negedge clk);
      smp_valid = 1'b0;
      cal_start = 1'b0;
      wr_en = 1'b0;
      chk("R7 done at last window sample", 32'(cal_done), 32'd1);
      chk("R4 last sample used zero offset", 32'(out_msq), 32'(cal_val(l + WN, l, base)));
      @(negedge clk);
      chk("R7 done lasts one cycle", 32'(cal_done), 32'd0);
      send_sample(24'hFFFFFF, 24'hFFFFFF - exp_off, "R5 R6 window mean stored as offset");
      send_sample(exp_off - 24'd1, 24'd0, "R3 just below calibrated offset");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_subtract();
      t_rescale();
      t_calibrate(5, 200, 1'b0, 1'b1);
      t_calibrate(0, 4000, 1'b1, 1'b0);
      t_calibrate(9, 70000, 1'b0, 1'b0);
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule